// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM from power-up to a state where normal accesses may begin. Once a start pulse is seen, it waits out a power-stabilization interval. It then issues one precharge covering all banks and a run of auto-refresh commands. After that it writes the mode register with a word fixed at build time. It waits through a final settle period and raises a done flag that stays high. All commands go out on a simple registered command interface: a 4-bit command code, bank and address lines, and a one-cycle valid strobe.

Every interval is given in microseconds and turned into clock cycles through a cycles-per-microsecond parameter. One shared down-counter times all of the intervals. The block does no read or write scheduling and no periodic refresh. Software cannot reach it. A synchronous reset is the only way to run the sequence again.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the outputs show the idle pattern: cmd = 4'b0111 (NOP, code bits {cs_n, ras_n, cas_n, we_n}), cmd_valid = 0, bank = 0, addr = 0, init_done = 0.
- R2: PRECHARGE ALL (cmd = 4'b0010, addr bit 10 = 1, all other address and bank bits 0) appears POWERUP_US*CYCLES_PER_US cycles after the clock edge that samples start.
- R3: Exactly NUM_REFRESH AUTO REFRESH commands (cmd = 4'b0001, bank and addr 0) follow the precharge. Each one appears STEP_US*CYCLES_PER_US cycles after the command before it.
- R4: The MODE REGISTER SET (cmd = 4'b0000, addr = MODE_WORD, bank = 0) appears STEP_US*CYCLES_PER_US cycles after the last refresh.
- R5: The block enters normal mode STEP_US*CYCLES_PER_US cycles after the mode write. init_done rises a further STEP_US*CYCLES_PER_US cycles later and stays high until reset.
- R6: Each command is driven for exactly one cycle with cmd_valid high. In every other cycle the outputs are NOP with cmd_valid low and bank and addr at 0.
- R7: A start pulse has no effect unless the block is idle, whether the sequence is still running or has finished. No second sequence begins.
- R8: A synchronous reset taken in the middle of a sequence returns the block to idle with init_done low. A later start then runs the full sequence from its first step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the sequence when the block is idle |
| cmd | output | 4 | Command code {cs_n, ras_n, cas_n, we_n} |
| bank | output | BANK_W (2) | Bank address |
| addr | output | ADDR_W (13) | Row/mode address lines |
| cmd_valid | output | 1 | High for the single cycle a command is driven |
| init_done | output | 1 | Sequence complete, memory ready for normal use |

## Verification
The bench holds its own schedule of event offsets for each accepted start and compares every output on every cycle, so any command that is early, late, missing or doubled shows up at once. Three start patterns are used. A clean start with an extra start pulse in the middle of the run shows that a busy sequencer ignores start. A start pulse after completion shows that a finished sequencer does not re-arm. A reset during the refresh train followed by a fresh start shows that reset clears the refresh count and the delay counter, so the second sequence is as long as the first.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command code bits: {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS       = 4'b0000,
    CMD_REFRESH   = 4'b0001,
    CMD_PRECHARGE = 4'b0010,
    CMD_NOP       = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POWER,
    ST_AFTER_PRE,
    ST_AFTER_REF,
    ST_AFTER_MRS,
    ST_SETTLE,
    ST_READY
  } seq_state_e;

endpackage

// File: rtl/sdram_init_delay.sv
module sdram_init_delay #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (load)          count <= load_val;
    else if (count != '0)   count <= count - 1'b1;
  end

  assign expired = (count == '0);

  // The counter never wraps from zero when no load arrives (R6 timing base)
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> expired);

  // A loaded value is reflected on the next cycle (R2/R3 interval start)
  p_load_taken_r3: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/sdram_init_refcnt.sv
module sdram_init_refcnt #(
  parameter int LIMIT = 8,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);

  logic [W-1:0] issued;

  always_ff @(posedge clk) begin
    if (rst || clr) issued <= '0;
    else if (inc)   issued <= issued + 1'b1;
  end

  assign last = (issued == W'(LIMIT));

  // Never more refreshes counted than configured
  p_refcnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    issued <= W'(LIMIT));

  // No increment once the limit is reached
  p_no_extra_refresh_r3: assert property (@(posedge clk) disable iff (rst)
    last |-> !inc);

endmodule

// File: rtl/sdram_init_outreg.sv
module sdram_init_outreg #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [3:0]        issue_cmd,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              set_done,
  output logic [3:0]        cmd,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output logic              cmd_valid,
  output logic              init_done
);

  import sdram_init_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd       <= CMD_NOP;
      bank      <= '0;
      addr      <= '0;
      cmd_valid <= 1'b0;
      init_done <= 1'b0;
    end else begin
      cmd       <= issue ? issue_cmd : CMD_NOP;
      bank      <= '0;
      addr      <= issue ? issue_addr : '0;
      cmd_valid <= issue;
      if (set_done) init_done <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int              CYCLES_PER_US = 50,
  parameter int              POWERUP_US    = 200,
  parameter int              STEP_US       = 100,
  parameter int              NUM_REFRESH   = 8,
  parameter int              ADDR_W        = 13,
  parameter int              BANK_W        = 2,
  parameter int              AP_BIT        = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD   = 13'h0032
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [3:0]        cmd,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output logic              cmd_valid,
  output logic              init_done
);

  import sdram_init_pkg::*;

  localparam int NP    = POWERUP_US * CYCLES_PER_US;
  localparam int NS    = STEP_US * CYCLES_PER_US;
  localparam int MAXD  = (NP > NS) ? NP : NS;
  localparam int DLY_W = $clog2(MAXD + 1);
  localparam logic [DLY_W-1:0]  NP_LOAD  = DLY_W'(NP - 1);
  localparam logic [DLY_W-1:0]  NS_LOAD  = DLY_W'(NS - 1);
  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << AP_BIT;

  seq_state_e        state, state_nxt;
  logic              dly_load, dly_expired;
  logic [DLY_W-1:0]  dly_val;
  logic              ref_clr, ref_inc, ref_last;
  logic              issue, set_done;
  logic [3:0]        issue_cmd;
  logic [ADDR_W-1:0] issue_addr;

  sdram_init_delay #(.W(DLY_W)) u_delay (
    .clk      (clk),
    .rst      (rst),
    .load     (dly_load),
    .load_val (dly_val),
    .expired  (dly_expired)
  );

  sdram_init_refcnt #(.LIMIT(NUM_REFRESH)) u_refcnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (ref_clr),
    .inc  (ref_inc),
    .last (ref_last)
  );

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nxt;
  end

  always_comb begin
    state_nxt  = state;
    dly_load   = 1'b0;
    dly_val    = NS_LOAD;
    ref_clr    = 1'b0;
    ref_inc    = 1'b0;
    issue      = 1'b0;
    issue_cmd  = CMD_NOP;
    issue_addr = '0;
    set_done   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          state_nxt = ST_POWER;
          dly_load  = 1'b1;
          dly_val   = NP_LOAD;
          ref_clr   = 1'b1;
        end
      end
      ST_POWER: begin
        if (dly_expired) begin
          issue      = 1'b1;
          issue_cmd  = CMD_PRECHARGE;
          issue_addr = PRE_ADDR;
          dly_load   = 1'b1;
          state_nxt  = ST_AFTER_PRE;
        end
      end
      ST_AFTER_PRE: begin
        if (dly_expired) begin
          issue     = 1'b1;
          issue_cmd = CMD_REFRESH;
          ref_inc   = 1'b1;
          dly_load  = 1'b1;
          state_nxt = ST_AFTER_REF;
        end
      end
      ST_AFTER_REF: begin
        if (dly_expired) begin
          issue    = 1'b1;
          dly_load = 1'b1;
          if (ref_last) begin
            issue_cmd  = CMD_MRS;
            issue_addr = MODE_WORD;
            state_nxt  = ST_AFTER_MRS;
          end else begin
            issue_cmd = CMD_REFRESH;
            ref_inc   = 1'b1;
          end
        end
      end
      ST_AFTER_MRS: begin
        if (dly_expired) begin
          dly_load  = 1'b1;
          state_nxt = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (dly_expired) begin
          set_done  = 1'b1;
          state_nxt = ST_READY;
        end
      end
      default: state_nxt = ST_READY;
    endcase
  end

  sdram_init_outreg #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_cmd  (issue_cmd),
    .issue_addr (issue_addr),
    .set_done   (set_done),
    .cmd        (cmd),
    .bank       (bank),
    .addr       (addr),
    .cmd_valid  (cmd_valid),
    .init_done  (init_done)
  );

  // Commands are single-cycle strobes
  p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // Without a strobe the bus shows NOP
  p_nop_between_r6: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> (cmd == CMD_NOP && addr == '0));

  // Precharge carries the all-banks bit
  p_pre_all_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_PRECHARGE) |-> addr == PRE_ADDR);

  // Mode write carries the configured word
  p_mrs_word_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_MRS) |-> addr == MODE_WORD);

  // Done is sticky and no command follows it
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    init_done |=> (init_done && !cmd_valid));

  // Leaving reset always lands in idle
  p_reset_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!init_done && !cmd_valid));

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  localparam int CPU     = 2;
  localparam int PWR_US  = 200;
  localparam int STEP_US = 100;
  localparam int NREF    = 8;
  localparam int AW      = 13;
  localparam int BW      = 2;
  localparam logic [AW-1:0] MW = 13'h0232;
  localparam int NP = PWR_US * CPU;
  localparam int NS = STEP_US * CPU;
  localparam int T_DONE = NP + (NREF + 3) * NS;

  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0]    cmd;
  logic [BW-1:0] bank;
  logic [AW-1:0] addr;
  logic          cmd_valid, init_done;

  always #10 clk = ~clk;

  sdram_init_seq #(
    .CYCLES_PER_US(CPU), .POWERUP_US(PWR_US), .STEP_US(STEP_US),
    .NUM_REFRESH(NREF), .ADDR_W(AW), .BANK_W(BW), .AP_BIT(10), .MODE_WORD(MW)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .bank(bank),
    .addr(addr), .cmd_valid(cmd_valid), .init_done(init_done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int pre_seen = 0;

  typedef struct { int t; logic [3:0] c; logic [AW-1:0] a; } ev_t;
  ev_t sched[$];
  bit  m_active = 0;
  int  m_elapsed = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Behavioural reference: schedule of command offsets from the accepting edge
  always @(posedge clk) begin
    if (rst) begin
      m_active  = 0;
      m_elapsed = 0;
      sched.delete();
    end else if (!m_active) begin
      if (start) begin
        m_active  = 1;
        m_elapsed = 0;
        sched.delete();
        sched.push_back('{NP, C_PRE, 13'h0400});
        for (int i = 1; i <= NREF; i++) sched.push_back('{NP + i*NS, C_REF, '0});
        sched.push_back('{NP + (NREF+1)*NS, C_MRS, MW});
      end
    end else begin
      m_elapsed++;
    end
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    logic [3:0]    e_cmd;
    logic [AW-1:0] e_addr;
    logic          e_valid, e_done;
    string         tag;
    if (!finished) begin
      e_cmd = C_NOP; e_addr = '0; e_valid = 0;
      e_done = m_active && (m_elapsed >= T_DONE);
      tag = m_active ? (e_done ? "R5" : "R6") : "R1";
      foreach (sched[i]) begin
        if (m_active && sched[i].t == m_elapsed) begin
          e_cmd = sched[i].c; e_addr = sched[i].a; e_valid = 1;
          tag = (e_cmd == C_PRE) ? "R2" : (e_cmd == C_REF) ? "R3" : "R4";
        end
      end
      if (cmd_valid && cmd == C_PRE) pre_seen++;
      check({cmd_valid, cmd, bank, addr, init_done} ==
            {e_valid, e_cmd, 2'b00, e_addr, e_done}, tag, "outputs",
            32'({cmd_valid, cmd, bank, addr, init_done}),
            32'({e_valid, e_cmd, 2'b00, e_addr, e_done}));
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cmd == C_NOP && !cmd_valid && !init_done, "R1", "reset idle",
          32'({cmd_valid, cmd, init_done}), 32'({1'b0, C_NOP, 1'b0}));
    rst = 1'b0;
    // Run 1: extra start while busy (R7)
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    repeat (T_DONE) @(negedge clk);
    check(init_done === 1'b1, "R5", "done after run 1", 32'(init_done), 32'd1);
    // Start after completion must be ignored (R7)
    pulse_start();
    repeat (300) @(negedge clk);
    check(pre_seen == 1 && init_done, "R7", "no re-arm", 32'(pre_seen), 32'd1);
    // Reset during refresh train (R8)
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    pulse_start();
    repeat (1000) @(negedge clk);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check(!init_done && !cmd_valid && cmd == C_NOP, "R8", "idle after mid reset",
          32'({init_done, cmd_valid, cmd}), 32'({1'b0, 1'b0, C_NOP}));
    repeat (50) @(negedge clk);
    pulse_start();
    repeat (T_DONE + 20) @(negedge clk);
    check(pre_seen == 3, "R8", "precharge count", 32'(pre_seen), 32'd3);
    check(init_done === 1'b1, "R8", "full rerun done", 32'(init_done), 32'd1);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule